// File: doc/BRIEF.md
# Synchronized Periodic Match Timer

This block is an 8-bit up-counter that advances on the falling edges of a slow timer clock. The timer clock arrives from another domain. The block samples it in the system clock domain and turns each falling edge into a one-cycle count strobe. Software writes a compare value into a data register. When the counter has reached that value, the next strobe wraps the counter to zero and produces a one-cycle interrupt pulse. This gives an interrupt period of (data + 1) timer-clock periods.

Starting and stopping are requested by write-one command bits. Neither command acts at once. Each is held pending and takes effect on the next timer-clock falling edge. A start raises the running flag on that edge, and counting begins on the edge after it. A stop lets one final count happen on the edge that consumes it, and clears the running flag on that same edge. A later start resumes from the held count. Writing the counter location clears the counter. The counter value and the running flag are always visible on output ports.

Top module: `sync_match_timer`

## Requirements
- R1: After reset the counter reads 00H, the running flag is 0, the interrupt is low, and the compare value is FFH.
- R2: After a run command, the first timer-clock falling edge sets the running flag without changing the counter. The counter first increments on the second falling edge.
- R3: While running, the counter increments by exactly one per timer-clock falling edge. It holds its value while the timer clock is idle.
- R4: When a falling edge arrives with the counter equal to the compare value, the counter becomes 00H and the interrupt pulses on that edge. This gives one interrupt every (compare + 1) falling edges, including for a compare value of 01H.
- R5: After a stop command, the next falling edge still counts and clears the running flag. Later falling edges leave the counter unchanged.
- R6: A run command after a stop resumes counting from the held counter value, with no clearing.
- R7: A write to the counter location (select 1) clears the counter to 00H at once, whatever data is written.
- R8: If the edge that consumes a stop also finds the counter equal to the compare value, the interrupt pulses, the counter wraps to 00H, and the running flag clears.
- R9: Run and stop written in the same cycle act as a stop.
- R10: The interrupt is high for exactly one system-clock cycle per wrap.
- R11: Register selects are: 0 = command (bit 0 run, bit 1 stop), 1 = counter clear, 2 = compare value. A write to select 3, or a command write with neither bit set, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Timer clock, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| cnt_out | output | 8 | Current counter value |
| running | output | 1 | Running flag |
| irq | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
The hardest situation to reach is a stop request and a compare match landing on the same timer-clock edge. This needs the counter to sit exactly at the compare value while a stop is still pending. The bench reaches it by stepping the timer clock one falling edge at a time from a task. It issues the stop write after the edge that brings the counter to the compare value and before the next edge. It then checks the interrupt count, the wrapped counter and the cleared flag together. The same single-edge stepping places the run-and-stop collision and the compare value of 01H exactly.

// File: rtl/sync_tmr_pkg.sv
package sync_tmr_pkg;

    localparam int TMR_W = 8;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic stop;
        logic clr;
        logic cmp_we;
    } wr_dec_t;

    typedef struct packed {
        logic pend_start;
        logic pend_stop;
        logic active;
    } ctl_state_t;

    function automatic wr_dec_t decode_write(input logic en, input logic [1:0] sel,
                                             input logic [1:0] cmd_bits);
        wr_dec_t d;
        d = '0;
        if (en) begin
            unique case (reg_sel_e'(sel))
                SEL_CMD: begin
                    d.run  = cmd_bits[0];
                    d.stop = cmd_bits[1];
                end
                SEL_CNT:  d.clr    = 1'b1;
                SEL_CMP:  d.cmp_we = 1'b1;
                default:  d        = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/tck_edge_det.sv
module tck_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tck_in,
    output logic fall_stb
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= tck_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign fall_stb = prev_q & ~sync_q[STAGES-1];

    // R10: a strobe never lasts two cycles
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> !fall_stb);

endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
    import sync_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_cmd,
    input  logic stop_cmd,
    input  logic stb,
    output logic active
);
    ctl_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            if (st_q.pend_stop)       st_d.active = 1'b0;
            else if (st_q.pend_start) st_d.active = 1'b1;
            st_d.pend_start = 1'b0;
            st_d.pend_stop  = 1'b0;
        end
        if (stop_cmd) begin
            st_d.pend_stop  = 1'b1;
            st_d.pend_start = 1'b0;
        end else if (run_cmd) begin
            st_d.pend_start = 1'b1;
            st_d.pend_stop  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active = st_q.active;

    // R2: the flag only rises on a timer-clock edge
    a_r2_rise_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(stb));
    // R5: the flag only falls on a timer-clock edge
    a_r5_fall_on_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(stb));
    // R9: stop wins over a simultaneous run
    a_r9_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (run_cmd && stop_cmd) |=> !st_q.pend_start);

endmodule

// File: rtl/match_counter.sv
module match_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic         count_en,
    input  logic         clr,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_in,
    output logic [W-1:0] cnt,
    output logic         irq
);
    localparam logic [W-1:0] CMP_RST = {W{1'b1}};

    logic [W-1:0] cnt_q, cmp_q;
    logic         irq_q;
    logic         step, hit;

    assign step = stb & count_en & ~clr;
    assign hit  = (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cmp_q <= CMP_RST;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cmp_we) cmp_q <= cmp_in;
            if (clr) begin
                cnt_q <= '0;
            end else if (step) begin
                if (hit) begin
                    cnt_q <= '0;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;

    // R4: an interrupt always comes with a wrapped counter
    a_r4_irq_wraps: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt_q == '0));
    // R4: an interrupt follows a counter that sat at the compare value
    a_r4_irq_from_match: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(cnt_q) == $past(cmp_q)));
    // R3: a counting edge below the compare value adds one
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (step && !hit) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R3: no edge, no change
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!stb && !clr) |=> $stable(cnt_q));
    // R7: a counter write clears it
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/sync_match_timer.sv
module sync_match_timer
    import sync_tmr_pkg::*;
#(
    parameter int W           = TMR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tck,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_out,
    output logic         running,
    output logic         irq
);
    wr_dec_t wd;
    logic    stb;

    assign wd = decode_write(wr_en, wr_sel, wr_data[1:0]);

    tck_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .tck_in   (tck),
        .fall_stb (stb)
    );

    run_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run_cmd  (wd.run),
        .stop_cmd (wd.stop),
        .stb      (stb),
        .active   (running)
    );

    match_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .stb      (stb),
        .count_en (running),
        .clr      (wd.clr),
        .cmp_we   (wd.cmp_we),
        .cmp_in   (wr_data),
        .cnt      (cnt_out),
        .irq      (irq)
    );

    // R5: an idle timer never moves except through a clear
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !wd.clr) |=> $stable(cnt_out));

endmodule

// File: tb/sync_match_timer_test.sv
`timescale 1ns/1ps
module sync_match_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tck = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_out;
    logic       running;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_cnt  = 0;
    int irq_run  = 0;
    int irq_max  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sync_match_timer uut (
        .clk(clk), .rst(rst), .tck(tck), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cnt_out(cnt_out), .running(running), .irq(irq)
    );

    always @(negedge clk) begin
        if (!rst && irq) begin
            irq_cnt++;
            irq_run++;
            if (irq_run > irq_max) irq_max = irq_run;
        end else begin
            irq_run = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'd0;
    endtask

    task automatic tfall(input int n);
        for (int i = 0; i < n; i++) begin
            tck = 1'b1;
            repeat (4) @(negedge clk);
            tck = 1'b0;
            repeat (4) @(negedge clk);
        end
        tck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(cnt_out == 8'd0, "R1 counter", cnt_out, 0);
        chk(running == 1'b0, "R1 flag", running, 0);
        chk(irq_cnt == 0, "R1 irq", irq_cnt, 0);
        tfall(2);
        chk(cnt_out == 8'd0 && !running, "R1 idle after reset", cnt_out, 0);
    endtask

    task automatic t_start_count;
        wr(2'd2, 8'd5);
        wr(2'd0, 8'h01);
        chk(running == 1'b0, "R2 no effect before edge", running, 0);
        tfall(1);
        chk(running == 1'b1, "R2 flag on first edge", running, 1);
        chk(cnt_out == 8'd0, "R2 no count on first edge", cnt_out, 0);
        tfall(1);
        chk(cnt_out == 8'd1, "R2 count on second edge", cnt_out, 1);
        tfall(2);
        chk(cnt_out == 8'd3, "R3 one per edge", cnt_out, 3);
        repeat (30) @(negedge clk);
        chk(cnt_out == 8'd3, "R3 hold without edges", cnt_out, 3);
    endtask

    task automatic t_match;
        int base;
        base = irq_cnt;
        tfall(2);
        chk(cnt_out == 8'd5 && irq_cnt == base, "R4 at compare, no irq yet", cnt_out, 5);
        tfall(1);
        chk(cnt_out == 8'd0, "R4 wrap", cnt_out, 0);
        chk(irq_cnt == base + 1, "R4 irq on edge after match", irq_cnt, base + 1);
        tfall(5);
        chk(irq_cnt == base + 1, "R4 no early irq", irq_cnt, base + 1);
        tfall(1);
        chk(irq_cnt == base + 2, "R4 period compare+1", irq_cnt, base + 2);
        chk(irq_max == 1, "R10 pulse width", irq_max, 1);
    endtask

    task automatic t_stop_resume;
        tfall(2);
        wr(2'd0, 8'h02);
        chk(running == 1'b1, "R5 stop waits for edge", running, 1);
        tfall(1);
        chk(cnt_out == 8'd3, "R5 final count", cnt_out, 3);
        chk(running == 1'b0, "R5 flag cleared", running, 0);
        tfall(3);
        chk(cnt_out == 8'd3, "R5 halted", cnt_out, 3);
        wr(2'd0, 8'h01);
        tfall(1);
        chk(cnt_out == 8'd3 && running, "R6 resume keeps value", cnt_out, 3);
        tfall(1);
        chk(cnt_out == 8'd4, "R6 resume counts on", cnt_out, 4);
    endtask

    task automatic t_stop_match;
        int base;
        tfall(1);
        chk(cnt_out == 8'd5, "R8 at compare", cnt_out, 5);
        base = irq_cnt;
        wr(2'd0, 8'h02);
        tfall(1);
        chk(irq_cnt == base + 1, "R8 irq with stop", irq_cnt, base + 1);
        chk(cnt_out == 8'd0, "R8 wrapped", cnt_out, 0);
        chk(running == 1'b0, "R8 halted", running, 0);
        tfall(2);
        chk(cnt_out == 8'd0 && irq_cnt == base + 1, "R8 stays halted", cnt_out, 0);
    endtask

    task automatic t_clear;
        wr(2'd0, 8'h01);
        tfall(3);
        chk(cnt_out == 8'd2, "R7 precondition", cnt_out, 2);
        wr(2'd1, 8'hA5);
        chk(cnt_out == 8'd0, "R7 write clears", cnt_out, 0);
        tfall(1);
        chk(cnt_out == 8'd1, "R7 counts from zero", cnt_out, 1);
    endtask

    task automatic t_both_cmds;
        wr(2'd0, 8'h03);
        tfall(1);
        chk(running == 1'b0, "R9 stop wins", running, 0);
        chk(cnt_out == 8'd2, "R9 final count", cnt_out, 2);
        tfall(1);
        chk(cnt_out == 8'd2, "R9 halted", cnt_out, 2);
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'h00);
        tfall(2);
        chk(running == 1'b0 && cnt_out == 8'd2, "R11 ignored writes", cnt_out, 2);
    endtask

    task automatic t_cmp_one;
        int base;
        wr(2'd2, 8'd1);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h01);
        tfall(2);
        chk(cnt_out == 8'd1 && running, "R4 compare 01H reach", cnt_out, 1);
        base = irq_cnt;
        tfall(1);
        chk(cnt_out == 8'd0 && irq_cnt == base + 1, "R4 compare 01H wrap", irq_cnt, base + 1);
        tfall(2);
        chk(irq_cnt == base + 2, "R4 compare 01H period 2", irq_cnt, base + 2);
        chk(irq_max == 1, "R10 pulse width", irq_max, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start_count();
        t_match();
        t_stop_resume();
        t_stop_match();
        t_clear();
        t_both_cmds();
        t_cmp_one();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1-chain actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule